// File: doc/BRIEF.md
# Prescaled Event Timer

An 8-bit up-counter that advances on a selectable clock event. The event source is either a one-cycle internal tick pulse (the instruction-cycle strobe of the host core) or an asynchronous external pin. The pin is brought into the clock domain by a two-flop synchronizer, and either its rising or its falling edge is counted. Between the event source and the counter sits an 8-bit programmable divider that can be bypassed. Its division ratio is picked by a 3-bit selector.

Software reads the count at any time and may overwrite it. A write also restarts the divider and makes the block ignore the next two source events. This gives software a clean reload point. When the count wraps from FFh to 00h, a sticky overflow flag is raised. It stays set until software clears it, and a wrap in the same cycle as a clear keeps the flag set.

All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake is involved and nothing at the edge of the block can stall.

Top module: `presc_timer`

## Requirements
- R1: After reset the count is 00h, the overflow flag is 0 and the divider state is zero.
- R2: With `src_ext`=0 and `pre_bypass`=1, each cycle with `cyc_tick`=1 raises the count by one on that clock edge.
- R3: With `src_ext`=1 the counted event is a rising edge of `ext_in` when `edge_fall`=0 and a falling edge when `edge_fall`=1. Only one edge per pulse is counted. The count changes on the third rising clock edge after `ext_in` changes.
- R4: With `pre_bypass`=0 the counter advances once per 2^(`pre_sel`+1) source events: `pre_sel`=0 gives 2 and `pre_sel`=7 gives 256.
- R5: A cycle with `cnt_wr_en`=1 loads `cnt_wr_data` into the count on that edge and clears the divider. The next two source events after the write are discarded.
- R6: A count increment from FFh to 00h sets `ovf_flag`. An increment to any other value does not set it.
- R7: `ovf_flag` stays set until a cycle with `flag_clr`=1. If a wrap and `flag_clr` fall in the same cycle, the flag stays 1.
- R8: Events from the source that is not selected have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | Internal tick, one-cycle pulse per event |
| ext_in | input | 1 | Asynchronous external event pin |
| src_ext | input | 1 | 1 selects the external pin, 0 selects the internal tick |
| edge_fall | input | 1 | 1 counts falling edges of the pin, 0 counts rising edges |
| pre_bypass | input | 1 | 1 bypasses the divider (ratio 1:1) |
| pre_sel | input | 3 | Divider ratio select, ratio 2^(pre_sel+1) |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_data | input | 8 | Value loaded on a count write |
| flag_clr | input | 1 | Clears the overflow flag |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Some properties are checked on every cycle by the assertions:
- the count moves only by one step or by a load;
- no increment passes while the post-write hold is active;
- the divider is restarted by a write;
- a detected pin edge is never reported twice in a row;
- the flag sets on a wrap and is sticky.

The bench scenarios are needed for behaviours that depend on the input history. They sweep every divider ratio plus the bypass path from a reload. They also check the exact three-edge latency and the polarity choice for the external pin, the two discarded events after a write, and the tie between a wrap and a clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {SRC_CYCLE = 1'b0, SRC_PIN = 1'b1} src_sel_e;
  typedef enum logic {POL_RISE = 1'b0, POL_FALL = 1'b1} edge_pol_e;

  // Mask of divider bits that must all be one for a division by 2^(sel+1).
  function automatic logic [7:0] div_mask8(input logic [2:0] sel);
    logic [7:0] m;
    for (int k = 0; k < 8; k++) m[k] = (int'(sel) >= k);
    return m;
  endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic fall_sel,
  output logic edge_evt
);
  import tmr_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              synced;
  edge_pol_e         pol;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;

  always_comb begin
    pol = edge_pol_e'(fall_sel);
    if (pol == POL_FALL) edge_evt = prev_q & ~synced;
    else                 edge_evt = ~prev_q & synced;
  end

  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> (!edge_evt || fall_sel != $past(fall_sel)));  // R3
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W      = 8,
  parameter int SEL_W      = 3,
  parameter int HOLD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             restart,
  input  logic             bypass,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             cnt_tick
);
  localparam int HOLD_W = (HOLD_TICKS > 0) ? $clog2(HOLD_TICKS + 1) : 1;

  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  mask;
  logic [HOLD_W-1:0] hold_q;
  logic              holding;
  logic              live;
  logic              wrap;

  generate
    if (HOLD_TICKS > 0) begin : g_hold
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                  hold_q <= '0;
        else if (restart)            hold_q <= HOLD_W'(HOLD_TICKS);
        else if (src_tick && holding) hold_q <= hold_q - 1'b1;
      assign holding = (hold_q != '0);
    end else begin : g_nohold
      assign hold_q  = '0;
      assign holding = 1'b0;
    end
  endgenerate

  always_comb begin
    mask = '0;
    for (int k = 0; k < PRE_W; k++) mask[k] = (int'(ratio_sel) >= k);
  end

  assign live     = src_tick && !holding && !restart;
  assign wrap     = &(pre_q | ~mask);
  assign cnt_tick = live && (bypass || wrap);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               pre_q <= '0;
    else if (restart)         pre_q <= '0;
    else if (live && !bypass) pre_q <= pre_q + 1'b1;

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    holding |-> !cnt_tick);  // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));  // R5
  AST_TICK_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |-> src_tick);  // R4
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);
  logic wrap_evt;

  assign wrap_evt = cnt_tick && !wr_en && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt_q <= '0;
    else if (wr_en)    cnt_q <= wr_data;
    else if (cnt_tick) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap_evt) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data)));  // R5
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));  // R2
  AST_NO_OVERFLOW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !wr_en && cnt_q == '1) |=> flag_q);  // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);  // R7
endmodule

// File: rtl/presc_timer.sv
module presc_timer #(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             ext_in,
  input  logic             src_ext,
  input  logic             edge_fall,
  input  logic             pre_bypass,
  input  logic [SEL_W-1:0] pre_sel,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_flag
);
  import tmr_pkg::*;

  logic     pin_evt;
  logic     src_tick;
  logic     cnt_tick;
  src_sel_e src;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_in),
    .fall_sel (edge_fall),
    .edge_evt (pin_evt)
  );

  always_comb begin
    src      = src_sel_e'(src_ext);
    src_tick = (src == SRC_PIN) ? pin_evt : cyc_tick;
  end

  tmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W), .HOLD_TICKS(HOLD_TICKS)) i_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .restart   (cnt_wr_en),
    .bypass    (pre_bypass),
    .ratio_sel (pre_sel),
    .cnt_tick  (cnt_tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) i_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_tick (cnt_tick),
    .wr_en    (cnt_wr_en),
    .wr_data  (cnt_wr_data),
    .flag_clr (flag_clr),
    .cnt_q    (cnt_q),
    .flag_q   (ovf_flag)
  );

  AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |-> !cnt_tick);  // R5
endmodule

// File: tb/test_presc_timer.sv
`timescale 1ns/1ps
module test_presc_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0, ext_in = 1'b0, src_ext = 1'b0, edge_fall = 1'b0;
  logic       pre_bypass = 1'b1;
  logic [2:0] pre_sel = 3'd0;
  logic       cnt_wr_en = 1'b0;
  logic [7:0] cnt_wr_data = 8'd0;
  logic       flag_clr = 1'b0;
  logic [7:0] cnt_q;
  logic       ovf_flag;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  presc_timer i_presc_timer (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_in(ext_in),
    .src_ext(src_ext), .edge_fall(edge_fall), .pre_bypass(pre_bypass),
    .pre_sel(pre_sel), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .flag_clr(flag_clr), .cnt_q(cnt_q), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) cyc_tick = 1'b1;
    @(negedge clk) cyc_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk) begin cnt_wr_en = 1'b1; cnt_wr_data = v; end
    @(negedge clk) cnt_wr_en = 1'b0;
  endtask

  task automatic pin_pulse();
    @(negedge clk) ext_in = ~ext_in;
    repeat (4) @(negedge clk);
    ext_in = ~ext_in;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count after reset", int'(cnt_q), 0);
    chk("R1 flag after reset", int'(ovf_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: bypass, internal ticks, one per tick
    ticks(5);
    chk("R2 five ticks from reset", int'(cnt_q), 5);

    // R5: write loads and two events are discarded
    wr(8'd10);
    chk("R5 write loads value", int'(cnt_q), 10);
    tick();
    chk("R5 first event after write discarded", int'(cnt_q), 10);
    tick();
    chk("R5 second event after write discarded", int'(cnt_q), 10);
    tick();
    chk("R5 third event counts", int'(cnt_q), 11);

    // R4: sweep every divider ratio and bypass from a reload
    for (int bp = 0; bp < 2; bp++) begin
      for (int s = 0; s < 8; s++) begin
        int r;
        if (bp == 1 && s > 0) continue;
        pre_bypass = bp[0];
        pre_sel = s[2:0];
        r = (bp == 1) ? 1 : (1 << (s + 1));
        tick();                       // leave divider mid-phase before reload
        wr(8'd0);
        ticks(2 + 3 * r + r - 1);
        chk($sformatf("R4 ratio %0d count", r), int'(cnt_q), 3);
        if (r > 1) begin
          tick();
          chk($sformatf("R4 ratio %0d boundary", r), int'(cnt_q), 4);
        end
      end
    end
    pre_bypass = 1'b1;

    // R6: wrap sets flag
    wr(8'hFE);
    ticks(2);
    tick();
    chk("R6 FE to FF no flag", int'(ovf_flag), 0);
    chk("R6 count at FF", int'(cnt_q), 255);
    tick();
    chk("R6 wrap to 00", int'(cnt_q), 0);
    chk("R6 wrap sets flag", int'(ovf_flag), 1);

    // R7: sticky, clear, clear vs wrap
    ticks(3);
    chk("R7 flag sticky", int'(ovf_flag), 1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    chk("R7 clear drops flag", int'(ovf_flag), 0);
    wr(8'hFF);
    ticks(2);
    @(negedge clk) begin cyc_tick = 1'b1; flag_clr = 1'b1; end
    @(negedge clk) begin cyc_tick = 1'b0; flag_clr = 1'b0; end
    chk("R7 wrap beats clear", int'(ovf_flag), 1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;

    // R8: pin ignored in internal mode
    pin_pulse();
    pin_pulse();
    chk("R8 pin ignored with internal source", int'(cnt_q), 0);

    // R3: rising edges on pin
    src_ext = 1'b1;
    edge_fall = 1'b0;
    wr(8'd0);
    pin_pulse();
    pin_pulse();
    chk("R3 two edges discarded after write", int'(cnt_q), 0);
    @(negedge clk) ext_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 no change after two clock edges", int'(cnt_q), 0);
    @(negedge clk);
    chk("R3 change on third clock edge", int'(cnt_q), 1);
    repeat (3) @(negedge clk);
    ext_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 falling edge ignored in rising mode", int'(cnt_q), 1);
    pin_pulse();
    pin_pulse();
    chk("R3 rising edges counted", int'(cnt_q), 3);

    // R3: falling edges
    edge_fall = 1'b1;
    @(negedge clk) ext_in = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3 rising edge ignored in falling mode", int'(cnt_q), 3);
    ext_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 falling edge counted", int'(cnt_q), 4);

    // R8: internal tick ignored in pin mode
    ticks(4);
    chk("R8 internal tick ignored with pin source", int'(cnt_q), 4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule